// File: doc/BRIEF.md
# Trapping Integer ALU

A combinational 32-bit arithmetic and logic unit for a register machine whose arithmetic and logic instructions name two source registers and one destination. It adds, subtracts, performs AND, OR, XOR and NOR, and shifts left logically, right logically and right arithmetically. The second operand is either the second source register or a 16-bit immediate field. The shift amount comes either from a constant field of the instruction or from the low bits of the first source register.

Signed add and subtract raise a trap flag on two's-complement overflow. Their unsigned twins produce the same result bits and never raise the trap. Immediate operations are limited to add (signed and unsigned), AND, OR and XOR. A subtract of a constant is issued as an immediate add of the negated constant. A register move is issued as an add with register zero, and a bitwise NOT as an XOR with an all-ones register. The unit therefore has no encodings of its own for these.

Top module: `trap_alu`

## Requirements
- R1: op 0 (ADD), 1 (ADDU), 2 (SUB) and 3 (SUBU) give result = a+b (ops 0, 1) or a-b (ops 2, 3), modulo 2^32.
- R2: ADD (op 0), SUB (op 2) and ADDI (op 14) raise `ovf_trap_o` exactly when the exact signed result lies outside [-2^31, 2^31-1].
- R3: ADDU (op 1), SUBU (op 3) and ADDIU (op 15) produce the same result bits as their signed forms and never raise `ovf_trap_o`.
- R4: op 4 (AND), 5 (OR), 6 (XOR) and 7 (NOR) combine a and b bitwise; NOR gives ~(a|b).
- R5: ADDI (op 14) and ADDIU (op 15) add a to `imm_i` sign-extended from bit 15.
- R6: op 16 (ANDI), 17 (ORI) and 18 (XORI) combine a with `imm_i` zero-extended.
- R7: op 8 (SLL), 9 (SRL) and 10 (SRA) shift b by `shamt_i`.
- R8: op 11 (SLLV), 12 (SRLV) and 13 (SRAV) shift b by a[4:0]; bits a[31:5] have no effect.
- R9: arithmetic right shifts (ops 10, 13) fill vacated bits with b[31]; logical shifts (8, 9, 11, 12) fill with zero.
- R10: op codes 19 to 31 give result 0 and no trap.
- R11: logic and shift ops (4 to 13, 16 to 18) never raise `ovf_trap_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | 32 | First source register value |
| b_i | input | 32 | Second source register value, also the shifted value |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Constant shift amount field |
| result_o | output | 32 | Operation result |
| ovf_trap_o | output | 1 | Signed overflow trap request |

## Verification
The block holds no state, so a fault shows on the ports as soon as the inputs settle: a wrong result word or a wrong trap bit for the vector applied in that very cycle. The bench holds each vector for one clock and compares both outputs with a behavioural model that uses 64-bit signed sums and a bit-by-bit shift loop. Directed vectors cover the overflow edges, the immediate extension rules and the unused codes. Random vectors then exercise every op code.

// File: rtl/trap_alu.sv
module trap_alu #(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  parameter int OP_W  = 5,
  localparam int SH_W = $clog2(W)
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [SH_W-1:0]  shamt_i,
  output logic [W-1:0]     result_o,
  output logic             ovf_trap_o
);

  localparam logic [OP_W-1:0] OP_ADD   = 5'd0;
  localparam logic [OP_W-1:0] OP_ADDU  = 5'd1;
  localparam logic [OP_W-1:0] OP_SUB   = 5'd2;
  localparam logic [OP_W-1:0] OP_SUBU  = 5'd3;
  localparam logic [OP_W-1:0] OP_AND   = 5'd4;
  localparam logic [OP_W-1:0] OP_OR    = 5'd5;
  localparam logic [OP_W-1:0] OP_XOR   = 5'd6;
  localparam logic [OP_W-1:0] OP_NOR   = 5'd7;
  localparam logic [OP_W-1:0] OP_SLL   = 5'd8;
  localparam logic [OP_W-1:0] OP_SRL   = 5'd9;
  localparam logic [OP_W-1:0] OP_SRA   = 5'd10;
  localparam logic [OP_W-1:0] OP_SLLV  = 5'd11;
  localparam logic [OP_W-1:0] OP_SRLV  = 5'd12;
  localparam logic [OP_W-1:0] OP_SRAV  = 5'd13;
  localparam logic [OP_W-1:0] OP_ADDI  = 5'd14;
  localparam logic [OP_W-1:0] OP_ADDIU = 5'd15;
  localparam logic [OP_W-1:0] OP_ANDI  = 5'd16;
  localparam logic [OP_W-1:0] OP_ORI   = 5'd17;
  localparam logic [OP_W-1:0] OP_XORI  = 5'd18;
  localparam int M = W - 1;

  logic          imm_op;
  logic [W-1:0]  imm_sx, imm_zx, add_b, sum, diff;
  logic          add_ovf, sub_ovf;
  logic [SH_W-1:0] amt;

  assign imm_op = (op_i == OP_ADDI) || (op_i == OP_ADDIU);
  assign imm_sx = {{(W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign imm_zx = {{(W-IMM_W){1'b0}}, imm_i};
  assign add_b  = imm_op ? imm_sx : b_i;
  assign sum    = a_i + add_b;
  assign diff   = a_i - b_i;

  assign add_ovf = (a_i[M] == add_b[M]) && (sum[M] != a_i[M]);
  assign sub_ovf = (a_i[M] != b_i[M]) && (diff[M] != a_i[M]);

  assign amt = (op_i == OP_SLLV || op_i == OP_SRLV || op_i == OP_SRAV)
             ? a_i[SH_W-1:0] : shamt_i;

  always_comb begin
    result_o   = '0;
    ovf_trap_o = 1'b0;
    case (op_i)
      OP_ADD, OP_ADDI:   begin result_o = sum;  ovf_trap_o = add_ovf; end
      OP_ADDU, OP_ADDIU: result_o = sum;
      OP_SUB:            begin result_o = diff; ovf_trap_o = sub_ovf; end
      OP_SUBU:           result_o = diff;
      OP_AND:            result_o = a_i & b_i;
      OP_OR:             result_o = a_i | b_i;
      OP_XOR:            result_o = a_i ^ b_i;
      OP_NOR:            result_o = ~(a_i | b_i);
      OP_ANDI:           result_o = a_i & imm_zx;
      OP_ORI:            result_o = a_i | imm_zx;
      OP_XORI:           result_o = a_i ^ imm_zx;
      OP_SLL, OP_SLLV:   result_o = b_i << amt;
      OP_SRL, OP_SRLV:   result_o = b_i >> amt;
      OP_SRA, OP_SRAV:   result_o = W'($signed(b_i) >>> amt);
      default:           result_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == OP_ADDU || op_i == OP_SUBU || op_i == OP_ADDIU)
      AST_UNSIGNED_NO_TRAP: assert (!ovf_trap_o); // R3
    if ((op_i >= OP_AND && op_i <= OP_SRAV) || op_i >= OP_ANDI)
      AST_LOGIC_NO_TRAP: assert (!ovf_trap_o); // R11
    if (ovf_trap_o)
      AST_TRAP_SIGN_FLIP: assert (result_o[M] != a_i[M]); // R2
    if ((op_i == OP_SRA || op_i == OP_SRAV))
      AST_SRA_SIGN_KEPT: assert (result_o[M] == b_i[M]); // R9
    if ((op_i == OP_SRL || op_i == OP_SRLV) && amt != '0)
      AST_SRL_ZERO_FILL: assert (!result_o[M]); // R9
    if ((op_i == OP_SLL || op_i == OP_SLLV) && amt != '0)
      AST_SLL_ZERO_FILL: assert (!result_o[0]); // R7
    if (op_i > OP_XORI)
      AST_UNUSED_QUIET: assert (result_o == '0 && !ovf_trap_o); // R10
  end

endmodule

// File: tb/trap_alu_tb_top.sv
`timescale 1ns/1ps
module trap_alu_tb_top;

  logic        clk = 1'b0;
  logic [4:0]  op;
  logic [31:0] a, b;
  logic [15:0] imm;
  logic [4:0]  sh;
  logic [31:0] res;
  logic        trap;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  trap_alu dut_i (
    .op_i(op), .a_i(a), .b_i(b), .imm_i(imm), .shamt_i(sh),
    .result_o(res), .ovf_trap_o(trap)
  );

  function automatic string req_of(input logic [4:0] o);
    if (o <= 3) return "R1";
    if (o <= 7) return "R4";
    if (o <= 10) return "R7";
    if (o <= 13) return "R8";
    if (o <= 15) return "R5";
    if (o <= 18) return "R6";
    return "R10";
  endfunction

  function automatic void model(input logic [4:0] o, input logic [31:0] x,
                                input logic [31:0] y, input logic [15:0] im,
                                input logic [4:0] s, output logic [31:0] r,
                                output logic t);
    longint sx, sy, exact;
    int k;
    logic [31:0] ext;
    r = 32'd0; t = 1'b0;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    ext = {{16{im[15]}}, im};
    k = (o >= 11 && o <= 13) ? int'(x[4:0]) : int'(s);
    case (o)
      0, 1:  begin exact = sx + sy; r = exact[31:0]; t = (o == 0) && (exact > 64'sd2147483647 || exact < -64'sd2147483648); end
      2, 3:  begin exact = sx - sy; r = exact[31:0]; t = (o == 2) && (exact > 64'sd2147483647 || exact < -64'sd2147483648); end
      14, 15: begin exact = sx + longint'($signed(ext)); r = exact[31:0]; t = (o == 14) && (exact > 64'sd2147483647 || exact < -64'sd2147483648); end
      4: r = x & y;
      5: r = x | y;
      6: r = x ^ y;
      7: r = ~(x | y);
      16: r = x & {16'd0, im};
      17: r = x | {16'd0, im};
      18: r = x ^ {16'd0, im};
      8, 11: for (int i = 0; i < 32; i++) r[i] = (i >= k) ? y[i-k] : 1'b0;
      9, 12: for (int i = 0; i < 32; i++) r[i] = (i + k < 32) ? y[i+k] : 1'b0;
      10, 13: for (int i = 0; i < 32; i++) r[i] = (i + k < 32) ? y[i+k] : y[31];
      default: r = 32'd0;
    endcase
  endfunction

  task automatic apply(input logic [4:0] o, input logic [31:0] x,
                       input logic [31:0] y, input logic [15:0] im,
                       input logic [4:0] s, input string tag);
    logic [31:0] er;
    logic et;
    @(posedge clk);
    op = o; a = x; b = y; imm = im; sh = s;
    @(negedge clk);
    model(o, x, y, im, s, er, et);
    checks++;
    if (res !== er) begin
      fails++;
      $display("FAIL %s result op=%0d: got %h expected %h", tag, o, res, er);
    end
    checks++;
    if (trap !== et) begin
      fails++;
      $display("FAIL %s trap op=%0d: got %b expected %b", tag, o, trap, et);
    end
  endtask

  initial begin
    op = 5'd31; a = '0; b = '0; imm = '0; sh = '0;
    @(negedge clk);
    checks++;
    if (res !== 32'd0 || trap !== 1'b0) begin
      fails++;
      $display("FAIL R10 idle: got %h/%b expected 0/0", res, trap);
    end
    apply(0, 32'h7fffffff, 32'd1, 0, 0, "R2");
    apply(1, 32'h7fffffff, 32'd1, 0, 0, "R3");
    apply(0, 32'h80000000, 32'hffffffff, 0, 0, "R2");
    apply(0, 32'h7ffffffe, 32'd1, 0, 0, "R2");
    apply(2, 32'h80000000, 32'd1, 0, 0, "R2");
    apply(3, 32'h80000000, 32'd1, 0, 0, "R3");
    apply(2, 32'h7fffffff, 32'hffffffff, 0, 0, "R2");
    apply(2, 32'd5, 32'd9, 0, 0, "R1");
    apply(14, 32'h7fffffff, 0, 16'h0001, 0, "R2");
    apply(15, 32'h7fffffff, 0, 16'h0001, 0, "R3");
    apply(14, 32'h80000000, 0, 16'hffff, 0, "R2");
    apply(15, 32'd100, 0, 16'hfffe, 0, "R5");
    apply(16, 32'hffffffff, 0, 16'h8001, 0, "R6");
    apply(17, 32'd0, 0, 16'hf000, 0, "R6");
    apply(18, 32'hffffffff, 0, 16'hffff, 0, "R6");
    apply(7, 32'h0f0f0000, 32'h000000ff, 0, 0, "R4");
    apply(10, 0, 32'h80000000, 0, 5'd31, "R9");
    apply(9, 0, 32'h80000000, 0, 5'd31, "R9");
    apply(13, 32'hffffffe4, 32'h90000000, 0, 5'd0, "R8");
    apply(12, 32'h00000020, 32'h12345678, 0, 5'd7, "R8");
    apply(11, 32'hffffffff, 32'd1, 0, 5'd0, "R8");
    apply(8, 32'hdeadbeef, 32'h00000003, 0, 5'd30, "R7");
    apply(0, 32'd0, 32'h1234abcd, 0, 0, "R1");
    apply(6, 32'h5a5a5a5a, 32'hffffffff, 0, 0, "R4");
    apply(20, 32'hffffffff, 32'hffffffff, 16'hffff, 5'd31, "R10");
    apply(31, 32'h7fffffff, 32'd1, 0, 0, "R10");
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] o;
      o = 5'($urandom_range(0, 31));
      apply(o, $urandom, $urandom, 16'($urandom), 5'($urandom), req_of(o));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule